// File: doc/BRIEF.md
# Reader Command Frame Serializer

This block sits between a protocol controller and the host-bus port of a contactless reader front end. It accepts one transmit request at a time. A request is either a single short command byte, such as the wake-up probe 0x26, or a bit-oriented anticollision or select frame. Such a frame consists of a cascade selector byte, a valid-bits byte (NVB) and a prefix of the card identifier. The block expands the request into the complete byte sequence that the front end expects, one byte per handshake.

Each sequence begins with a FIFO clear command. A transmit command follows, with or without CRC. Next comes a burst-write address that opens the two transmit-length registers, then the two length bytes, then the payload. The front end frames the payload on air and holds it in a 12-byte data FIFO. For this reason a request whose payload would not fit is refused with a one-cycle error pulse, and nothing is emitted for it. Bus start and stop framing is represented by the valid/ready handshake and the last flag.

Top module: `cmd_frame_ser`

## Requirements
- R1: The first byte of every accepted, valid request is 0x8F. It appears on `out_byte` with `out_valid` high in the cycle after acceptance.
- R2: The second byte is 0x91 (send with CRC) or 0x90 (send without CRC). A short request takes this choice from `req_crc`. A frame request uses 0x91 exactly when NVB equals 0x70 (full select) and 0x90 otherwise.
- R3: The third byte is the burst-write address 0x3D.
- R4: For a short request (`req_frame`=0), the length bytes are 0x00 and 0x10: a count of one, with its low nibble in bits 7:4 of the second length byte. The only payload byte is `req_cmd`.
- R5: For a frame request, the first length byte is 0x00. The second is NVB with bits 3:0 cleared, ORed with (2·NVB[2:0]+1) when NVB[2:0] is non-zero. This places the partial-bit count in bits 3:1 and a partial-byte flag in bit 0.
- R6: The frame payload is the selector byte, then NVB, then identifier bytes, taking `req_uid[7:0]` first and moving upward. The identifier byte count is NVB[7:4]−2, plus one when NVB[2:0] is non-zero.
- R7: `out_last` is high on the final payload byte and on no other byte.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_last` and `out_valid` hold their values.
- R9: `req_ready` is low from the cycle after acceptance until the cycle after the last byte is taken. A request presented during that time is ignored.
- R10: A frame request whose payload count (NVB[7:4] plus one if NVB[2:0]≠0) exceeds 12 is refused. `req_err` is high for the one cycle after the request is presented, and no bytes are emitted.
- R11: A frame request with NVB[7:4] below 2 is refused in the same way as R10.
- R12: After reset, `req_ready` is 1 and both `out_valid` and `req_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_frame | input | 1 | 1: anticollision/select frame, 0: short command |
| req_crc | input | 1 | Short command is sent with CRC |
| req_cmd | input | 8 | Short command byte |
| req_sel | input | 8 | Cascade selector byte of a frame |
| req_nvb | input | 8 | Valid-bits byte of a frame |
| req_uid | input | 80 | Identifier prefix, byte 0 in bits 7:0 |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Serialized byte |
| out_last | output | 1 | Final byte of the sequence |
| req_err | output | 1 | One-cycle pulse for a refused request |

## Verification
The first output byte is due one clock after the request is accepted. Each later byte is due one clock after the previous one is taken, and an error pulse is due one clock after a refused request. The bench holds a queue of expected bytes, filled at the accepting edge and popped at each edge where the bench itself drives `out_ready` high. In the middle of every cycle it compares `req_ready`, `out_valid`, the head of the queue, `out_last` and `req_err`. Stalls from random back-pressure and requests presented while busy are therefore checked in the exact cycle in which they take effect.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  localparam logic [7:0] OP_FIFO_CLEAR  = 8'h8F;
  localparam logic [7:0] OP_SEND_RAW    = 8'h90;
  localparam logic [7:0] OP_SEND_CRC    = 8'h91;
  localparam logic [7:0] OP_LEN_BURST   = 8'h3D;
  localparam logic [7:0] NVB_FULL_SEL   = 8'h70;
  localparam int         HDR_BYTES      = 5;

  // Payload bytes implied by a valid-bits byte: whole bytes plus one partial.
  function automatic logic [4:0] nvb_payload(input logic [7:0] nvb);
    return {1'b0, nvb[7:4]} + {4'b0000, |nvb[2:0]};
  endfunction

  // Second length byte for a frame: byte nibble plus partial-bit code and flag.
  function automatic logic [7:0] nvb_len_lo(input logic [7:0] nvb);
    logic [7:0] v;
    v = {nvb[7:4], 4'h0};
    if (nvb[2:0] != 3'b000)
      v = v | (({5'b00000, nvb[2:0]} << 1) + 8'd1);
    return v;
  endfunction

  // Byte count split: upper and middle nibble, then low nibble moved up.
  function automatic logic [7:0] count_hi(input logic [11:0] n);
    return n[11:4];
  endfunction

  function automatic logic [7:0] count_lo(input logic [11:0] n);
    return {n[3:0], 4'h0};
  endfunction

endpackage

// File: rtl/cfs_build.sv
module cfs_build
  import cfs_pkg::*;
#(
  parameter int FIFO_DEPTH = 12,
  localparam int UID_MAX   = FIFO_DEPTH - 2,
  localparam int FRAME_MAX = HDR_BYTES + FIFO_DEPTH,
  localparam int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic                   req_frame,
  input  logic                   req_crc,
  input  logic [7:0]             req_cmd,
  input  logic [7:0]             req_sel,
  input  logic [7:0]             req_nvb,
  input  logic [8*UID_MAX-1:0]   req_uid,
  output logic [8*FRAME_MAX-1:0] frame_flat,
  output logic [CW-1:0]          frame_len,
  output logic                   frame_bad
);

  logic [7:0] tx_b, len_hi_b, len_lo_b;
  logic [4:0] pay_n;

  always_comb begin
    if (req_frame) begin
      tx_b     = (req_nvb == NVB_FULL_SEL) ? OP_SEND_CRC : OP_SEND_RAW;
      len_hi_b = 8'h00;
      len_lo_b = nvb_len_lo(req_nvb);
      pay_n    = nvb_payload(req_nvb);
    end else begin
      tx_b     = req_crc ? OP_SEND_CRC : OP_SEND_RAW;
      len_hi_b = count_hi(12'd1);
      len_lo_b = count_lo(12'd1);
      pay_n    = 5'd1;
    end
  end

  assign frame_bad = req_frame &&
                     ((req_nvb[7:4] < 4'd2) || (int'(pay_n) > FIFO_DEPTH));
  assign frame_len = CW'(pay_n) + CW'(HDR_BYTES);

  assign frame_flat[8*HDR_BYTES-1:0] =
    {len_lo_b, len_hi_b, OP_LEN_BURST, tx_b, OP_FIFO_CLEAR};

  for (genvar j = 0; j < FIFO_DEPTH; j++) begin : g_slot
    if (j == 0) begin : g_first
      assign frame_flat[8*(HDR_BYTES+j) +: 8] = req_frame ? req_sel : req_cmd;
    end else if (j == 1) begin : g_nvb
      assign frame_flat[8*(HDR_BYTES+j) +: 8] = req_frame ? req_nvb : 8'h00;
    end else begin : g_uid
      assign frame_flat[8*(HDR_BYTES+j) +: 8] =
        req_frame ? req_uid[8*(j-2) +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/cfs_stream.sv
module cfs_stream #(
  parameter int FRAME_MAX = 17,
  localparam int CW       = $clog2(FRAME_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [8*FRAME_MAX-1:0] frame_in,
  input  logic [CW-1:0]          len_in,
  input  logic                   out_ready,
  output logic                   busy,
  output logic                   out_valid,
  output logic [7:0]             out_byte,
  output logic                   out_last,
  output logic                   drain_ev
);

  logic [8*FRAME_MAX-1:0] sh_q;
  logic [CW-1:0]          left_q;
  logic                   pop_ev;

  assign out_valid = (left_q != '0);
  assign busy      = out_valid;
  assign out_byte  = sh_q[7:0];
  assign out_last  = (left_q == CW'(1));
  assign pop_ev    = out_valid && out_ready;
  assign drain_ev  = pop_ev && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= frame_in;
      left_q <= len_in;
    end else if (pop_ev) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - CW'(1);
    end
  end

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

  // R7
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ev |=> !out_valid);

endmodule

// File: rtl/cmd_frame_ser.sv
module cmd_frame_ser
  import cfs_pkg::*;
#(
  parameter int FIFO_DEPTH = 12,
  localparam int UID_MAX   = FIFO_DEPTH - 2,
  localparam int FRAME_MAX = HDR_BYTES + FIFO_DEPTH,
  localparam int CW        = $clog2(FRAME_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_frame,
  input  logic                 req_crc,
  input  logic [7:0]           req_cmd,
  input  logic [7:0]           req_sel,
  input  logic [7:0]           req_nvb,
  input  logic [8*UID_MAX-1:0] req_uid,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_byte,
  output logic                 out_last,
  output logic                 req_err
);

  logic [8*FRAME_MAX-1:0] frame_flat;
  logic [CW-1:0]          frame_len;
  logic                   frame_bad;
  logic                   busy;
  logic                   accept_ev, start_ev, reject_ev, drain_ev;
  logic                   err_q;

  cfs_build #(.FIFO_DEPTH(FIFO_DEPTH)) u_build (
    .req_frame  (req_frame),
    .req_crc    (req_crc),
    .req_cmd    (req_cmd),
    .req_sel    (req_sel),
    .req_nvb    (req_nvb),
    .req_uid    (req_uid),
    .frame_flat (frame_flat),
    .frame_len  (frame_len),
    .frame_bad  (frame_bad)
  );

  assign req_ready = !busy;
  assign accept_ev = req_valid && req_ready;
  assign start_ev  = accept_ev && !frame_bad;
  assign reject_ev = accept_ev && frame_bad;

  cfs_stream #(.FRAME_MAX(FRAME_MAX)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ev),
    .frame_in  (frame_flat),
    .len_in    (frame_len),
    .out_ready (out_ready),
    .busy      (busy),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_last  (out_last),
    .drain_ev  (drain_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= reject_ev;
  end
  assign req_err = err_q;

  // R1
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (out_valid && out_byte == OP_FIFO_CLEAR));

  // R9
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  // R10
  reject_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (req_err && !out_valid));

  // R9
  ready_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ev |=> req_ready);

endmodule

// File: tb/cmd_frame_ser_test.sv
module cmd_frame_ser_test;

  localparam int CLK_PERIOD = 10;
  localparam int UIDW       = 80;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_frame = 1'b0;
  logic            req_crc = 1'b0;
  logic [7:0]      req_cmd = 8'h00;
  logic [7:0]      req_sel = 8'h00;
  logic [7:0]      req_nvb = 8'h00;
  logic [UIDW-1:0] req_uid = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [7:0]      out_byte;
  logic            out_last;
  logic            req_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_ser uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_frame(req_frame), .req_crc(req_crc), .req_cmd(req_cmd),
    .req_sel(req_sel), .req_nvb(req_nvb), .req_uid(req_uid),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .req_err(req_err)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit stall  = 1'b0;
  bit done   = 1'b0;

  logic [7:0] expq[$];
  int         tagq[$];
  bit         err_exp = 1'b0;
  int         err_tag = 10;

  task automatic check(input bit ok, input int tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Reference model: expected byte stream built from the requirements.
  task automatic build_expected();
    int bc, bits, n;
    if (!req_frame) begin
      expq.push_back(8'h8F); tagq.push_back(1);                        // R1
      expq.push_back(req_crc ? 8'h91 : 8'h90); tagq.push_back(2);      // R2
      expq.push_back(8'h3D); tagq.push_back(3);                        // R3
      expq.push_back(8'h00); tagq.push_back(4);                        // R4
      expq.push_back(8'h10); tagq.push_back(4);
      expq.push_back(req_cmd); tagq.push_back(4);
    end else begin
      bc   = int'(req_nvb) / 16;
      bits = int'(req_nvb) % 8;
      n    = bc + ((bits != 0) ? 1 : 0);
      if (bc < 2) begin
        err_exp = 1'b1; err_tag = 11;                                  // R11
      end else if (n > 12) begin
        err_exp = 1'b1; err_tag = 10;                                  // R10
      end else begin
        expq.push_back(8'h8F); tagq.push_back(1);
        expq.push_back((req_nvb == 8'h70) ? 8'h91 : 8'h90); tagq.push_back(2);
        expq.push_back(8'h3D); tagq.push_back(3);
        expq.push_back(8'h00); tagq.push_back(5);                      // R5
        expq.push_back(8'((bc * 16) + ((bits != 0) ? (bits * 2 + 1) : 0))); tagq.push_back(5);
        expq.push_back(req_sel); tagq.push_back(6);                    // R6
        expq.push_back(req_nvb); tagq.push_back(6);
        for (int k = 0; k < n - 2; k++) begin
          expq.push_back(req_uid[8*k +: 8]); tagq.push_back(6);
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      expq.delete(); tagq.delete(); err_exp = 1'b0;
    end else begin
      err_exp = 1'b0;
      if (expq.size() > 0) begin
        if (out_ready) begin
          void'(expq.pop_front());
          void'(tagq.pop_front());
        end
      end else if (req_valid) begin
        build_expected();
      end
    end
  end

  // Comparison away from the active edge, every cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_ready == (expq.size() == 0), 9, int'(req_ready), int'(expq.size() == 0)); // R9
      check(out_valid == (expq.size() > 0), 9, int'(out_valid), int'(expq.size() > 0));
      if (expq.size() > 0) begin
        check(out_byte == expq[0], tagq[0], int'(out_byte), int'(expq[0]));
        check(out_last == (expq.size() == 1), 7, int'(out_last), int'(expq.size() == 1)); // R7
      end
      check(req_err == err_exp, err_tag, int'(req_err), int'(err_exp));
    end
  end

  // Back-pressure pattern (R8 stalls).
  always @(negedge clk) out_ready <= stall ? 1'($urandom % 2) : 1'b1;

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic send(input bit frame, input logic [7:0] cmd, input bit crc,
                      input logic [7:0] sel, input logic [7:0] nvb,
                      input logic [UIDW-1:0] uid, input int junk);
    @(negedge clk);
    while (expq.size() != 0) @(negedge clk);
    req_frame = frame; req_cmd = cmd; req_crc = crc;
    req_sel = sel; req_nvb = nvb; req_uid = uid; req_valid = 1'b1;
    @(negedge clk);
    // R9: requests while busy must be ignored
    for (int i = 0; i < junk; i++) begin
      req_frame = 1'b0; req_cmd = 8'hE5; req_crc = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [UIDW-1:0] UID_A = 80'hAA99_8877_6655_4433_2211;
  localparam logic [UIDW-1:0] UID_B = 80'h0F1E_2D3C_4B5A_6978_8796;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1, 12, int'(req_ready), 1);
    check(out_valid == 1'b0, 12, int'(out_valid), 0);
    check(req_err == 1'b0, 12, int'(req_err), 0);

    send(1'b0, 8'h26, 1'b0, 8'h00, 8'h00, '0, 0);    // R4 probe, no CRC
    send(1'b0, 8'h52, 1'b1, 8'h00, 8'h00, '0, 0);    // R2 short with CRC
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'h20, UID_A, 0); // R5 no prefix
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'h25, UID_A, 0); // R5 partial byte
    send(1'b1, 8'h00, 1'b0, 8'h95, 8'h29, UID_B, 0); // R5 bit 3 ignored
    send(1'b1, 8'h00, 1'b0, 8'h95, 8'h40, UID_B, 0); // R6
    send(1'b1, 8'h00, 1'b0, 8'h97, 8'h57, UID_A, 0); // R6
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'h70, UID_A, 0); // R2 full select
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'hC0, UID_B, 0); // R10 boundary fits
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'hB1, UID_B, 0); // R10 boundary fits
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'hC1, UID_A, 0); // R10 refused
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'hF7, UID_A, 0); // R10 refused
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'h10, UID_A, 0); // R11 refused
    send(1'b1, 8'h00, 1'b0, 8'h93, 8'h07, UID_A, 0); // R11 refused
    send(1'b1, 8'h00, 1'b0, 8'h95, 8'h33, UID_B, 3); // R9 busy requests
    stall = 1'b1;                                    // R8 back-pressure
    for (int r = 0; r < 6; r++) begin
      send(1'b1, 8'h00, 1'b0, 8'h93, 8'((r * 16 + 8'h21) & 8'h7F), UID_A ^ UID_B, 2);
      send(1'b0, 8'h26, r[0], 8'h00, 8'h00, '0, 1);
    end
    send(1'b1, 8'h00, 1'b0, 8'h97, 8'h70, UID_B, 0);
    stall = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule